// File: doc/BRIEF.md
# Free-Running Majority-Vote Serial Receiver

This block receives asynchronous serial bytes (one start bit, eight data bits sent least significant bit first, one stop bit) using a x16 oversampling enable. A 4-bit phase counter advances on every enable pulse and wraps every sixteen pulses. Nothing realigns it, and the falling edge of a start bit leaves it untouched. Once per wrap, the line is read at three fixed phases, and a two-of-three vote turns the three readings into one bit decision.

The voted bits drive a small frame machine. It treats a voted 0 seen while idle as a start bit, collects eight data bits, and judges the stop bit. The received byte is presented with a one-cycle strobe. A framing flag goes with the byte. A sticky overrun flag records a byte that arrived while the previous one was still unacknowledged. Baud generation, buffering and parity lie outside the block.

Top module: `mv_uart_rx`

## Requirements
- R1: The serial input passes through two flip-flops clocked by the system clock before any sample is taken, and the line reads as idle (1) while reset is held.
- R2: The phase counter resets to 0, advances by one only on cycles where `tick16` is 1, wraps from 15 to 0, and is never reloaded by activity on the serial line.
- R3: Samples are taken on ticks at phases 6, 7 and 8. The voted bit is 1 exactly when at least two of the three samples are 1, so one wrong sample in the window does not change the result.
- R4: Exactly one voted bit is produced per sixteen ticks. It becomes visible to the frame machine in the clock cycle after the phase-8 tick.
- R5: While idle, a voted 0 starts a frame. The next eight voted bits form the byte, with the first one received placed at `rx_data[0]`.
- R6: When the tenth voted bit of a frame (the stop bit) is evaluated, `rx_valid` is 1 for exactly one cycle, and `rx_data` holds the byte until the next frame completes.
- R7: `frame_err` is updated together with each `rx_valid` pulse and equals 1 when the voted stop bit was 0. After such a frame the receiver accepts no start bit until it has seen a voted 1.
- R8: If a byte completes while an earlier byte is still pending, `overrun` becomes 1 and stays 1 until `ovr_clr` is 1. A byte is pending from its `rx_valid` pulse until a cycle in which `rd_ack` is 1. An `rd_ack` in the completion cycle itself counts as acknowledging the earlier byte first.
- R9: While `rst_n` is 0 at a clock edge, `rx_valid`, `rx_data`, `frame_err` and `overrun` become 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | One-cycle enable at sixteen times the bit rate |
| rx_async | input | 1 | Asynchronous serial line, idle high |
| rd_ack | input | 1 | Acknowledges the pending byte |
| ovr_clr | input | 1 | Clears the overrun flag |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a completed frame |
| frame_err | output | 1 | Stop bit of the last frame was voted 0 |
| overrun | output | 1 | Sticky flag for a byte that overwrote an unacknowledged one |

## Verification
The in-line assertions check the following on every cycle:
- The phase counter holds between ticks and wraps correctly.
- Each vote follows a tick.
- `rx_valid` never lasts two cycles and only follows a vote.
- A new framing error only appears with a strobe.
- `overrun` stays set until cleared.

Only the bench scenarios can show that whole bytes come out right when frames start at different phases. The same holds for these behaviours:
- A single glitched sample is out-voted.
- A low line after a bad stop bit is not mistaken for a start.
- An unacknowledged byte produces an overrun that clears on request.

These scenarios are compared cycle by cycle against a behavioural model.

// File: rtl/mv_uart_rx_pkg.sv
// Shared types for the free-running majority-vote serial receiver.
package mv_uart_rx_pkg;

    // Frame machine states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DATA  = 2'd1,
        ST_STOP  = 2'd2,
        ST_WAIT1 = 2'd3
    } rx_state_e;

endpackage

// File: rtl/mv_sync.sv
// Multi-stage synchroniser for one asynchronous bit.
// Assumes the input is idle high; the chain resets to 1 so no false start is seen.
module mv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/mv_sampler.sv
// Free-running oversampling phase counter with a 2-of-3 majority vote.
// The counter only advances on tick16. Line activity never resets it.
// Three samples are taken at phases FIRST, FIRST+1 and FIRST+2, and the vote
// is registered on the last of them.
module mv_sampler #(
    parameter int OSR   = 16,
    parameter int FIRST = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick16,
    input  logic rx_s,
    output logic vote_vld,
    output logic vote_bit
);
    localparam int PH_W = $clog2(OSR);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
    localparam logic [PH_W-1:0] PH_S0   = PH_W'(FIRST);
    localparam logic [PH_W-1:0] PH_S1   = PH_W'(FIRST + 1);
    localparam logic [PH_W-1:0] PH_S2   = PH_W'(FIRST + 2);

    logic [PH_W-1:0] phase;
    logic [1:0]      held;
    logic            maj;

    // Free-running phase counter, advanced by the oversampling enable
    always_ff @(posedge clk) begin
        if (!rst_n)      phase <= '0;
        else if (tick16) phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end

    // Capture the first two samples of the window
    always_ff @(posedge clk) begin
        if (!rst_n) held <= 2'b11;
        else if (tick16 && (phase == PH_S0 || phase == PH_S1))
            held <= {held[0], rx_s};
    end

    // Two of three: the current line value is the third sample
    assign maj = (held[1] & held[0]) | (held[1] & rx_s) | (held[0] & rx_s);

    // Register the vote on the third sample tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vote_vld <= 1'b0;
            vote_bit <= 1'b1;
        end else begin
            vote_vld <= tick16 && (phase == PH_S2);
            if (tick16 && (phase == PH_S2)) vote_bit <= maj;
        end
    end

    // R2: the phase is frozen between ticks
    a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick16 |=> $stable(phase));
    // R2: the phase wraps to zero after the last position
    a_r2_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick16 && phase == PH_LAST) |=> (phase == '0));
    // R4: a vote only follows a tick
    a_r4_vote_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        vote_vld |-> $past(tick16));
endmodule

// File: rtl/mv_frame.sv
// Frame machine: start detect, LSB-first shift, stop check, byte strobe and overrun.
// Assumes vote_vld pulses at most once per bit period.
module mv_frame
    import mv_uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vote_vld,
    input  logic              vote_bit,
    input  logic              rd_ack,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              frame_err,
    output logic              overrun
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sr;
    logic              pending;
    logic              byte_done;

    assign byte_done = vote_vld && (state == ST_STOP);

    // Sequence start, data and stop bits on each vote
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            sr    <= '0;
        end else if (vote_vld) begin
            case (state)
                ST_IDLE: if (!vote_bit) begin
                    state <= ST_DATA;
                    cnt   <= '0;
                end
                ST_DATA: begin
                    sr  <= {vote_bit, sr[DATA_W-1:1]};
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_LAST) state <= ST_STOP;
                end
                ST_STOP:  state <= vote_bit ? ST_IDLE : ST_WAIT1;
                ST_WAIT1: if (vote_bit) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Present the byte, its strobe and its framing flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_valid  <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            rx_valid <= byte_done;
            if (byte_done) begin
                rx_data   <= sr;
                frame_err <= !vote_bit;
            end
        end
    end

    // Track the unacknowledged byte and the sticky overrun flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (byte_done)   pending <= 1'b1;
            else if (rd_ack) pending <= 1'b0;
            if (byte_done && pending && !rd_ack) overrun <= 1'b1;
            else if (ovr_clr)                    overrun <= 1'b0;
        end
    end

    // R6: the strobe is a single cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R6: the strobe only follows a vote
    a_r6_valid_from_vote: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(vote_vld));
    // R7: a new framing error appears only with a strobe
    a_r7_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> rx_valid);
    // R8: overrun stays set until cleared
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);
endmodule

// File: rtl/mv_uart_rx.sv
// Top level of the free-running majority-vote serial receiver.
// Assumes tick16 is a one-cycle pulse at sixteen times the bit rate.
module mv_uart_rx #(
    parameter int DATA_W   = 8,
    parameter int OSR      = 16,
    parameter int FIRST    = 6,
    parameter int SYNC_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rx_async,
    input  logic              rd_ack,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              frame_err,
    output logic              overrun
);
    logic rx_s;
    logic vote_vld;
    logic vote_bit;

    mv_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rx_async),
        .d_sync  (rx_s)
    );

    mv_sampler #(.OSR(OSR), .FIRST(FIRST)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick16   (tick16),
        .rx_s     (rx_s),
        .vote_vld (vote_vld),
        .vote_bit (vote_bit)
    );

    mv_frame #(.DATA_W(DATA_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .vote_vld  (vote_vld),
        .vote_bit  (vote_bit),
        .rd_ack    (rd_ack),
        .ovr_clr   (ovr_clr),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .frame_err (frame_err),
        .overrun   (overrun)
    );
endmodule

// File: tb/mv_uart_rx_tb_top.sv
// Bench: behavioural cycle model compared on every clock, plus scenario checks.
module mv_uart_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_async = 1'b1;
    logic       rd_ack = 1'b0;
    logic       ovr_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       frame_err;
    logic       overrun;

    int  tests = 0;
    int  fails = 0;
    int  cyc = 0;
    int  tick_cnt = 0;
    int  valid_seen = 0;
    bit  auto_ack = 1'b1;
    bit  clr_req = 1'b0;
    bit  ack_req = 1'b0;
    bit  done = 1'b0;
    bit  cmp_on = 1'b0;
    logic [7:0] exp_q[$];
    bit         exp_err_q[$];

    always #2 clk = ~clk;

    mv_uart_rx dut_i (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_async(rx_async),
        .rd_ack(rd_ack), .ovr_clr(ovr_clr), .rx_data(rx_data),
        .rx_valid(rx_valid), .frame_err(frame_err), .overrun(overrun)
    );

    // ---------------- behavioural reference model ----------------
    int   m_s1, m_s2, m_ph, m_st, m_n;
    int   m_samp[$];
    bit   m_vvld, m_vbit, m_valid, m_ferr, m_ovr, m_pend, m_oset;
    logic [7:0] m_sh, m_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_ph = 0; m_st = 0; m_n = 0;
            m_samp.delete();
            m_vvld = 0; m_vbit = 1; m_valid = 0; m_ferr = 0;
            m_ovr = 0; m_pend = 0; m_sh = 0; m_data = 0;
        end else begin
            m_valid = 0;
            m_oset  = 0;
            if (m_vvld) begin
                case (m_st)
                    0: if (!m_vbit) begin m_st = 1; m_n = 0; end
                    1: begin
                        m_sh[m_n] = m_vbit;
                        m_n++;
                        if (m_n == 8) m_st = 2;
                    end
                    2: begin
                        m_valid = 1;
                        m_data  = m_sh;
                        m_ferr  = !m_vbit;
                        if (m_pend && !rd_ack) begin m_ovr = 1; m_oset = 1; end
                        m_pend = 1;
                        m_st = m_vbit ? 0 : 3;
                    end
                    default: if (m_vbit) m_st = 0;
                endcase
            end
            if (!m_valid && rd_ack) m_pend = 0;
            if (!m_oset && ovr_clr) m_ovr = 0;
            m_vvld = tick16 && (m_ph == 8);
            if (m_vvld) begin
                int ones;
                ones = m_s2;
                foreach (m_samp[i]) ones += m_samp[i];
                m_vbit = (ones >= 2);
            end
            if (tick16 && m_ph == 6) m_samp.delete();
            if (tick16 && (m_ph == 6 || m_ph == 7)) m_samp.push_back(m_s2);
            if (tick16) m_ph = (m_ph + 1) % 16;
            m_s2 = m_s1;
            m_s1 = rx_async;
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            tests++;
            if (rx_valid !== m_valid) begin
                fails++;
                $display("FAIL R6 rx_valid cyc %0d: got %0b exp %0b", cyc, rx_valid, m_valid);
            end
            tests++;
            if (rx_data !== m_data) begin
                fails++;
                $display("FAIL R5 rx_data cyc %0d: got %02h exp %02h", cyc, rx_data, m_data);
            end
            tests++;
            if (frame_err !== m_ferr) begin
                fails++;
                $display("FAIL R7 frame_err cyc %0d: got %0b exp %0b", cyc, frame_err, m_ferr);
            end
            tests++;
            if (overrun !== m_ovr) begin
                fails++;
                $display("FAIL R8 overrun cyc %0d: got %0b exp %0b", cyc, overrun, m_ovr);
            end
            if (rx_valid) begin
                valid_seen++;
                tests++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R7 unexpected byte: got %02h exp none", rx_data);
                end else begin
                    logic [7:0] eb;
                    bit         ee;
                    eb = exp_q.pop_front();
                    ee = exp_err_q.pop_front();
                    if (rx_data !== eb || frame_err !== ee) begin
                        fails++;
                        $display("FAIL R5 byte: got %02h/%0b exp %02h/%0b", rx_data, frame_err, eb, ee);
                    end
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(negedge clk);
        cyc++;
        tick16  = (cyc % 4 == 0);
        if (tick16) tick_cnt++;
        rd_ack  = ack_req || (auto_ack && rx_valid);
        ack_req = 1'b0;
        ovr_clr = clr_req;
        clr_req = 1'b0;
    endtask

    // Wait until a tick is presented at the given phase
    task automatic align(input int ph);
        do step(); while (!(tick16 && ((tick_cnt - 1) % 16 == ph)));
    endtask

    // Send one frame; glitch_bit selects a bit whose middle tick is inverted (-1 none)
    task automatic send_frame(input logic [7:0] d, input bit stopv, input int glitch_bit);
        logic [9:0] bits;
        bits = {stopv, d, 1'b0};
        for (int b = 0; b < 10; b++) begin
            for (int c = 0; c < 64; c++) begin
                rx_async = (b == glitch_bit && c >= 28 && c < 32) ? !bits[b] : bits[b];
                step();
            end
        end
        rx_async = 1'b1;
    endtask

    task automatic check(input string tag, input bit ok, input int got, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d exp %0d", tag, got, exp);
        end
    endtask

    // ---------------- main sequence ----------------
    initial begin
        for (int i = 0; i < 5; i++) step();
        // R9: reset state
        check("R9 rx_valid reset", rx_valid === 1'b0, rx_valid, 0);
        check("R9 rx_data reset", rx_data === 8'h00, rx_data, 0);
        check("R9 flags reset", {frame_err, overrun} === 2'b00, {frame_err, overrun}, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        for (int i = 0; i < 80; i++) step();
        check("R1 idle line yields no byte", valid_seen == 0, valid_seen, 0);

        // R5: plain frames, start aligned to phase 0
        align(0); exp_q.push_back(8'hA5); exp_err_q.push_back(0); send_frame(8'hA5, 1, -1);
        align(0); exp_q.push_back(8'h01); exp_err_q.push_back(0); send_frame(8'h01, 1, -1);
        for (int i = 0; i < 80; i++) step();
        check("R5 two bytes decoded", valid_seen == 2, valid_seen, 2);

        // R2: start edge at a different phase; counter not realigned
        align(10); exp_q.push_back(8'h3C); exp_err_q.push_back(0); send_frame(8'h3C, 1, -1);
        for (int i = 0; i < 80; i++) step();
        check("R2 byte at offset phase", valid_seen == 3, valid_seen, 3);

        // R3: a glitch on the middle sample is out-voted (high bit and low bit)
        align(0); exp_q.push_back(8'hFF); exp_err_q.push_back(0); send_frame(8'hFF, 1, 4);
        align(0); exp_q.push_back(8'h00); exp_err_q.push_back(0); send_frame(8'h00, 1, 6);
        for (int i = 0; i < 80; i++) step();
        check("R3 glitched frames decoded", valid_seen == 5, valid_seen, 5);

        // R7: bad stop bit, then a held-low line must not start a frame
        align(0); exp_q.push_back(8'h5A); exp_err_q.push_back(1); send_frame(8'h5A, 0, -1);
        rx_async = 1'b0;
        for (int i = 0; i < 64 * 3; i++) step();
        rx_async = 1'b1;
        for (int i = 0; i < 64 * 2; i++) step();
        check("R7 no start while waiting for high", valid_seen == 6, valid_seen, 6);
        check("R7 framing flag held", frame_err === 1'b1, frame_err, 1);
        align(0); exp_q.push_back(8'hC3); exp_err_q.push_back(0); send_frame(8'hC3, 1, -1);
        for (int i = 0; i < 80; i++) step();
        check("R7 flag cleared by good frame", frame_err === 1'b0, frame_err, 0);

        // R8: two bytes without acknowledge set overrun; clear request drops it
        auto_ack = 1'b0;
        align(0); exp_q.push_back(8'h11); exp_err_q.push_back(0); send_frame(8'h11, 1, -1);
        align(0); exp_q.push_back(8'h22); exp_err_q.push_back(0); send_frame(8'h22, 1, -1);
        for (int i = 0; i < 80; i++) step();
        check("R8 overrun set", overrun === 1'b1, overrun, 1);
        for (int i = 0; i < 40; i++) step();
        check("R8 overrun sticky", overrun === 1'b1, overrun, 1);
        clr_req = 1'b1;
        step(); step(); step();
        check("R8 overrun cleared", overrun === 1'b0, overrun, 0);
        ack_req = 1'b1;
        step();
        auto_ack = 1'b1;
        align(0); exp_q.push_back(8'h77); exp_err_q.push_back(0); send_frame(8'h77, 1, -1);
        for (int i = 0; i < 80; i++) step();
        check("R8 no overrun after ack", overrun === 1'b0, overrun, 0);
        check("R4 one byte per frame", valid_seen == 10, valid_seen, 10);
        check("R6 all expected bytes seen", exp_q.size() == 0, exp_q.size(), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule